// File: doc/BRIEF.md
# Low-Voltage Supervisor Control Logic

This block is the digital side of a supply monitor. An analog front end gives it three already-digitized comparator levels:
- power-on reset active,
- supply below the selected detect threshold,
- supply below the selected warning threshold.

The block passes each level through a two-flop synchronizer. From the synchronized levels it decides whether to hold the system in reset, raise a detect interrupt or raise a warning interrupt.

Software controls the block through two small control registers on a simple write port with a combinational read mux. A third, read-only register records why the last reset hold happened. The block also drives the threshold select lines back to the analog side and a monitor-active line. It takes a level that says the system is in a stop mode. When detection is kept running in stop, a request for the deep stop mode is demoted to the shallow one.

Reset hold comes from either of two causes:
- a power-on condition, which holds reset until the supply is back above the low detect level;
- a low-voltage trip while reset response is enabled, which holds reset until the supply is back above the selected detect level.

While reset is held, every control bit returns to its default. The reset-source register is loaded at the moment the hold is released.

Top module: `lvsup_top`

## Requirements
- R1: After reset release, control register A (address 0) reads 0x05 and control register B (address 1) reads 0x00, and both interrupts are low. Register A holds detect-enable in bit 0, stop-keep in bit 1, reset-enable in bit 2, detect interrupt-enable in bit 3, detect-acknowledge in bit 4 and the detect flag in bit 7. Register B holds detect-select in bit 0, warning-select in bit 1, warning interrupt-enable in bit 2, warning-acknowledge in bit 3 and the warning flag in bit 7.
- R2: `mon_on` equals detect-enable AND (NOT `stop_in` OR stop-keep). When `mon_on` is 0, a low detect level causes neither a reset hold nor a flag.
- R3: `stop_deep_o` equals `stop_deep` AND NOT (detect-enable AND stop-keep).
- R4: Three clock edges after `por_raw` rises, `sys_rst_hold` is 1; after two edges it is still 0. The hold is released only when both `por_raw` and `below_det_raw` have been 0 for three edges.
- R5: At hold release the reset-source register (address 2) loads bit 0 = 1 if the cause was power-on, else 0, and bit 1 = 1. The ports `src_por` and `src_lv` show the same bits.
- R6: With reset-enable 1 and `mon_on` 1, `sys_rst_hold` rises three edges after `below_det_raw` rises. It stays 1 until `below_det_raw` has been 0 for three edges.
- R7: With reset-enable 0, detect interrupt-enable 1 and `mon_on` 1, a low detect level sets the detect flag three edges later, and `det_irq` follows the flag.
- R8: Writing 1 to detect-acknowledge clears the detect flag on that edge, unless the low condition is still present, in which case the flag stays set. The acknowledge bit reads back as 0.
- R9: The warning flag sets when the synchronized warning level is 1 and the synchronized detect level is 0, with `mon_on` 1. `warn_irq` is the flag AND warning interrupt-enable. Writing 1 to warning-acknowledge clears the flag.
- R10: `det_sel_o` and `warn_sel_o` follow register B bits 0 and 1.
- R11: While `sys_rst_hold` is 1, the control registers return to their defaults and both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| por_raw | input | 1 | Power-on comparator level, 1 = active |
| below_det_raw | input | 1 | 1 = supply below selected detect threshold |
| below_warn_raw | input | 1 | 1 = supply below selected warning threshold |
| stop_in | input | 1 | 1 = system is in a stop mode |
| stop_deep | input | 1 | 1 = deepest stop mode requested |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| sys_rst_hold | output | 1 | System reset hold |
| det_irq | output | 1 | Detect interrupt request |
| warn_irq | output | 1 | Warning interrupt request |
| src_por | output | 1 | Reset source: power-on |
| src_lv | output | 1 | Reset source: low voltage |
| mon_on | output | 1 | Monitoring active |
| det_sel_o | output | 1 | Detect threshold select to analog |
| warn_sel_o | output | 1 | Warning threshold select to analog |
| stop_deep_o | output | 1 | Stop depth granted, 1 = deep |

## Verification
Every comparator-driven result is due on the third rising edge after the raw level changes: two synchronizer flops, then the hold state or flag register. The bench changes inputs at a falling edge and samples at the falling edge after the second and after the third rising edge, so both the "not yet" and the "now" values are checked. Register writes take effect on the single edge after the strobe and are sampled at the next falling edge. The read mux, `mon_on` and `stop_deep_o` are combinational and are sampled a small delay after their inputs change.

// File: rtl/lvsup_pkg.sv
package lvsup_pkg;

  localparam int LV_ADDR_W = 2;
  localparam int LV_DATA_W = 8;

  localparam logic [LV_ADDR_W-1:0] ADR_CTLA = 2'd0;
  localparam logic [LV_ADDR_W-1:0] ADR_CTLB = 2'd1;
  localparam logic [LV_ADDR_W-1:0] ADR_SRC  = 2'd2;

  // register A bit positions
  localparam int BA_DEN  = 0;
  localparam int BA_SKEEP = 1;
  localparam int BA_REN  = 2;
  localparam int BA_DIE  = 3;
  localparam int BA_DACK = 4;
  localparam int BA_FLAG = 7;
  // register B bit positions
  localparam int BB_DSEL = 0;
  localparam int BB_WSEL = 1;
  localparam int BB_WIE  = 2;
  localparam int BB_WACK = 3;
  localparam int BB_FLAG = 7;

  typedef enum logic [1:0] {
    HS_RUN      = 2'd0,
    HS_HOLD_POR = 2'd1,
    HS_HOLD_LV  = 2'd2
  } hold_st_t;

  typedef struct packed {
    logic det_ie;
    logic rst_en;
    logic stop_keep;
    logic det_en;
  } ctla_t;

  typedef struct packed {
    logic warn_ie;
    logic warn_sel;
    logic det_sel;
  } ctlb_t;

  localparam ctla_t CTLA_DEF = '{det_ie: 1'b0, rst_en: 1'b1, stop_keep: 1'b0, det_en: 1'b1};
  localparam ctlb_t CTLB_DEF = '{warn_ie: 1'b0, warn_sel: 1'b0, det_sel: 1'b0};

  function automatic logic mon_active_f(input logic den, input logic keep, input logic in_stop);
    return den & (~in_stop | keep);
  endfunction

  function automatic logic stop_deep_f(input logic deep_req, input logic den, input logic keep);
    return deep_req & ~(den & keep);
  endfunction

  function automatic logic [LV_DATA_W-1:0] pack_ctla(input ctla_t c, input logic flag);
    logic [LV_DATA_W-1:0] v;
    v = '0;
    v[BA_DEN]   = c.det_en;
    v[BA_SKEEP] = c.stop_keep;
    v[BA_REN]   = c.rst_en;
    v[BA_DIE]   = c.det_ie;
    v[BA_FLAG]  = flag;
    return v;
  endfunction

  function automatic logic [LV_DATA_W-1:0] pack_ctlb(input ctlb_t c, input logic flag);
    logic [LV_DATA_W-1:0] v;
    v = '0;
    v[BB_DSEL] = c.det_sel;
    v[BB_WSEL] = c.warn_sel;
    v[BB_WIE]  = c.warn_ie;
    v[BB_FLAG] = flag;
    return v;
  endfunction

  function automatic logic [LV_DATA_W-1:0] pack_src(input logic por, input logic lv);
    logic [LV_DATA_W-1:0] v;
    v = '0;
    v[0] = por;
    v[1] = lv;
    return v;
  endfunction

endpackage

// File: rtl/lvsup_sync.sv
module lvsup_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_raw,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/lvsup_hold.sv
module lvsup_hold
  import lvsup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic por_s,
  input  logic det_s,
  input  logic lv_trip,
  output logic hold,
  output logic src_por,
  output logic src_lv
);
  hold_st_t st_q, st_d;
  logic cause_por_q;
  logic release_ev;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_RUN: begin
        if (por_s)        st_d = HS_HOLD_POR;
        else if (lv_trip) st_d = HS_HOLD_LV;
      end
      HS_HOLD_POR: if (!por_s && !det_s) st_d = HS_RUN;
      HS_HOLD_LV: begin
        if (por_s)       st_d = HS_HOLD_POR;
        else if (!det_s) st_d = HS_RUN;
      end
      default: st_d = HS_HOLD_POR;
    endcase
  end

  assign release_ev = (st_q != HS_RUN) && (st_d == HS_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= HS_HOLD_POR;
      cause_por_q <= 1'b1;
      src_por     <= 1'b0;
      src_lv      <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d == HS_HOLD_POR)     cause_por_q <= 1'b1;
      else if (st_d == HS_HOLD_LV) cause_por_q <= 1'b0;
      if (release_ev) begin
        src_por <= cause_por_q;
        src_lv  <= 1'b1;
      end
    end
  end

  assign hold = (st_q != HS_RUN);

  AST_POR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    por_s |=> hold); // R4
  AST_LV_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    lv_trip |=> hold); // R6
  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && det_s) |=> hold); // R6
  AST_SRC_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> src_lv); // R5
endmodule

// File: rtl/lvsup_regs.sv
module lvsup_regs
  import lvsup_pkg::*;
#(
  parameter int ADDR_W = LV_ADDR_W,
  parameter int DATA_W = LV_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              det_s,
  input  logic              warn_s,
  input  logic              mon_active,
  input  logic              src_por,
  input  logic              src_lv,
  output ctla_t             ctla,
  output ctlb_t             ctlb,
  output logic              det_flag,
  output logic              warn_flag
);
  logic wr_a, wr_b;
  logic det_ack_wr, warn_ack_wr;
  logic det_set, warn_set;
  logic unused_wr_bits;

  assign wr_a        = wr_en && (wr_addr == ADR_CTLA);
  assign wr_b        = wr_en && (wr_addr == ADR_CTLB);
  assign det_ack_wr  = wr_a && wr_data[BA_DACK];
  assign warn_ack_wr = wr_b && wr_data[BB_WACK];
  assign det_set     = mon_active && ctla.det_ie && !ctla.rst_en && det_s;
  assign warn_set    = mon_active && warn_s && !det_s;
  assign unused_wr_bits = ^{wr_data[6:5], wr_data[7]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctla <= CTLA_DEF;
      ctlb <= CTLB_DEF;
    end else if (clr) begin
      ctla <= CTLA_DEF;
      ctlb <= CTLB_DEF;
    end else begin
      if (wr_a) begin
        ctla.det_en    <= wr_data[BA_DEN];
        ctla.stop_keep <= wr_data[BA_SKEEP];
        ctla.rst_en    <= wr_data[BA_REN];
        ctla.det_ie    <= wr_data[BA_DIE];
      end
      if (wr_b) begin
        ctlb.det_sel  <= wr_data[BB_DSEL];
        ctlb.warn_sel <= wr_data[BB_WSEL];
        ctlb.warn_ie  <= wr_data[BB_WIE];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_flag  <= 1'b0;
      warn_flag <= 1'b0;
    end else if (clr) begin
      det_flag  <= 1'b0;
      warn_flag <= 1'b0;
    end else begin
      if (det_set)         det_flag <= 1'b1;
      else if (det_ack_wr) det_flag <= 1'b0;
      if (warn_set)         warn_flag <= 1'b1;
      else if (warn_ack_wr) warn_flag <= 1'b0;
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADR_CTLA: rd_data = pack_ctla(ctla, det_flag);
      ADR_CTLB: rd_data = pack_ctlb(ctlb, warn_flag);
      ADR_SRC:  rd_data = pack_src(src_por, src_lv);
      default:  rd_data = '0;
    endcase
  end

  AST_DET_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (det_set && !clr) |=> det_flag); // R7
  AST_DET_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (det_ack_wr && !det_set) |=> !det_flag); // R8
  AST_WARN_ABOVE_DET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_flag) |-> $past(!det_s)); // R9
  AST_DEFAULTS_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ctla.det_en && ctla.rst_en && !ctla.det_ie && !ctlb.warn_ie && !det_flag)); // R11
endmodule

// File: rtl/lvsup_top.sv
module lvsup_top
  import lvsup_pkg::*;
#(
  parameter int ADDR_W = LV_ADDR_W,
  parameter int DATA_W = LV_DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_raw,
  input  logic              below_det_raw,
  input  logic              below_warn_raw,
  input  logic              stop_in,
  input  logic              stop_deep,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              sys_rst_hold,
  output logic              det_irq,
  output logic              warn_irq,
  output logic              src_por,
  output logic              src_lv,
  output logic              mon_on,
  output logic              det_sel_o,
  output logic              warn_sel_o,
  output logic              stop_deep_o
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] raw_v, sync_v;
  logic por_s, det_s, warn_s;
  logic lv_trip;
  ctla_t ctla;
  ctlb_t ctlb;
  logic det_flag, warn_flag;

  assign raw_v = {below_warn_raw, below_det_raw, por_raw};

  lvsup_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL({NSIG{1'b1}})) sync_i (
    .clk(clk), .rst_n(rst_n), .d_raw(raw_v), .d_sync(sync_v)
  );

  assign por_s  = sync_v[0];
  assign det_s  = sync_v[1];
  assign warn_s = sync_v[2];

  assign mon_on      = mon_active_f(ctla.det_en, ctla.stop_keep, stop_in);
  assign stop_deep_o = stop_deep_f(stop_deep, ctla.det_en, ctla.stop_keep);
  assign lv_trip     = mon_on && ctla.rst_en && det_s;

  lvsup_hold hold_i (
    .clk(clk), .rst_n(rst_n), .por_s(por_s), .det_s(det_s), .lv_trip(lv_trip),
    .hold(sys_rst_hold), .src_por(src_por), .src_lv(src_lv)
  );

  lvsup_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .clr(sys_rst_hold),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .det_s(det_s), .warn_s(warn_s), .mon_active(mon_on),
    .src_por(src_por), .src_lv(src_lv),
    .ctla(ctla), .ctlb(ctlb), .det_flag(det_flag), .warn_flag(warn_flag)
  );

  assign det_irq    = det_flag && ctla.det_ie;
  assign warn_irq   = warn_flag && ctlb.warn_ie;
  assign det_sel_o  = ctlb.det_sel;
  assign warn_sel_o = ctlb.warn_sel;

  AST_DEEP_DEMOTED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctla.det_en && ctla.stop_keep) |-> !stop_deep_o); // R3
  AST_MON_GATED_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_in && !ctla.stop_keep) |-> !mon_on); // R2
  AST_NO_TRIP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_on && !por_s && !sys_rst_hold) |=> !sys_rst_hold); // R2
endmodule

// File: tb/lvsup_top_tb.sv
module lvsup_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic por_raw, below_det_raw, below_warn_raw, stop_in, stop_deep, wr_en;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic sys_rst_hold, det_irq, warn_irq, src_por, src_lv, mon_on;
  logic det_sel_o, warn_sel_o, stop_deep_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvsup_top dut_i (
    .clk(clk), .rst_n(rst_n), .por_raw(por_raw), .below_det_raw(below_det_raw),
    .below_warn_raw(below_warn_raw), .stop_in(stop_in), .stop_deep(stop_deep),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .sys_rst_hold(sys_rst_hold), .det_irq(det_irq),
    .warn_irq(warn_irq), .src_por(src_por), .src_lv(src_lv), .mon_on(mon_on),
    .det_sel_o(det_sel_o), .warn_sel_o(warn_sel_o), .stop_deep_o(stop_deep_o)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  logic [7:0] v;

  initial begin
    por_raw = 1; below_det_raw = 1; below_warn_raw = 1;
    stop_in = 0; stop_deep = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    tick(3);
    rst_n = 1;
    tick(1);
    chk(sys_rst_hold, 1, "R4 hold at power-up");
    por_raw = 0;
    tick(4);
    chk(sys_rst_hold, 1, "R4 hold while detect low");
    below_det_raw = 0; below_warn_raw = 0;
    tick(2);
    chk(sys_rst_hold, 1, "R4 hold two edges after clear");
    tick(1);
    chk(sys_rst_hold, 0, "R4 release at third edge");
    chk({src_lv, src_por}, 2'b11, "R5 source after power-on");
    rd(2, v); chk(v, 8'h03, "R5 source register read");
    rd(0, v); chk(v, 8'h05, "R1 ctl A default");
    rd(1, v); chk(v, 8'h00, "R1 ctl B default");
    chk({det_irq, warn_irq}, 0, "R1 irqs low");

    // low-voltage reset
    wr(0, 8'h07);
    below_det_raw = 1;
    tick(2);
    chk(sys_rst_hold, 0, "R6 not yet after two edges");
    tick(1);
    chk(sys_rst_hold, 1, "R6 hold at third edge");
    below_det_raw = 0;
    tick(2);
    chk(sys_rst_hold, 1, "R6 still held");
    tick(1);
    chk(sys_rst_hold, 0, "R6 released");
    chk({src_lv, src_por}, 2'b10, "R5 source after low-voltage");
    rd(0, v); chk(v, 8'h05, "R11 defaults restored");

    // power-on in run
    por_raw = 1;
    tick(2);
    chk(sys_rst_hold, 0, "R4 not yet");
    tick(1);
    chk(sys_rst_hold, 1, "R4 por hold");
    por_raw = 0;
    tick(3);
    chk({sys_rst_hold, src_lv, src_por}, 3'b011, "R5 por source again");

    // detection off
    wr(0, 8'h04);
    below_det_raw = 1;
    tick(4);
    chk(sys_rst_hold, 0, "R2 no reset when disabled");
    rd(0, v); chk(v, 8'h04, "R2 no flag when disabled");
    below_det_raw = 0; tick(3);
    wr(0, 8'h05);
    stop_in = 1; below_det_raw = 1;
    tick(4);
    chk(sys_rst_hold, 0, "R2 no reset in stop without keep");
    below_det_raw = 0; stop_in = 0; tick(3);

    // stop sweep
    for (int i = 0; i < 16; i++) begin
      logic den, keep, sreq, sdp;
      {den, keep, sreq, sdp} = i[3:0];
      wr(0, {6'b0, keep, den});
      stop_in = sreq; stop_deep = sdp;
      #1;
      chk(mon_on, den & (~sreq | keep), $sformatf("R2 mon_on combo %0d", i));
      chk(stop_deep_o, sdp & ~(den & keep), $sformatf("R3 stop depth combo %0d", i));
      @(negedge clk);
    end
    stop_in = 0; stop_deep = 0;

    // interrupt mode
    wr(0, 8'h09);
    below_det_raw = 1;
    tick(2);
    chk(det_irq, 0, "R7 flag not yet");
    tick(1);
    chk({sys_rst_hold, det_irq}, 2'b01, "R7 flag and irq");
    wr(0, 8'h19);
    rd(0, v); chk(v, 8'h89, "R8 set wins, ack reads 0");
    below_det_raw = 0; tick(3);
    rd(0, v); chk(v, 8'h89, "R7 flag sticky");
    wr(0, 8'h19);
    rd(0, v); chk(v, 8'h09, "R8 ack clears");
    chk(det_irq, 0, "R8 irq low after ack");

    // warning sweep
    wr(0, 8'h01);
    for (int i = 0; i < 8; i++) begin
      logic w, d, ie;
      {w, d, ie} = i[2:0];
      wr(1, {5'b0, ie, 2'b00});
      below_warn_raw = w; below_det_raw = d;
      tick(3);
      rd(1, v);
      chk(v[7], w & ~d, $sformatf("R9 warn flag combo %0d", i));
      chk(warn_irq, w & ~d & ie, $sformatf("R9 warn irq combo %0d", i));
      below_warn_raw = 0; below_det_raw = 0;
      tick(3);
      wr(1, {4'b0, 1'b1, ie, 2'b00});
      rd(1, v);
      chk(v, {5'b0, ie, 2'b00}, $sformatf("R9 warn ack combo %0d", i));
    end

    wr(1, 8'h03);
    chk({det_sel_o, warn_sel_o}, 2'b11, "R10 selects high");
    wr(1, 8'h02);
    chk({det_sel_o, warn_sel_o}, 2'b01, "R10 warn select only");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule